// File: doc/BRIEF.md
# Fixed-Latency Arbitrated Memory Port

This block is a small word-addressed write store, organised as lines of four 32-bit words, that two pipeline requesters share: a data-stage writer and a fetch-stage writer. Every write from either of them takes a fixed, parameterised number of wait cycles (`LATENCY`). The requester that starts first owns the store until its write completes. The other requester is told to wait, and it has no effect on the owner's progress.

A third port, the side port, writes at once. It bypasses both the latency and the ownership rule, so a bench or loader can preload contents without taking part in the timing. Each port returns a 1-bit status on the same cycle it presents a request: 0 means WAIT and 1 means OK. A view port returns a whole stored line combinationally, selected by line index, so that a checker can inspect the contents.

The ownership logic is a two-state machine with the states IDLE and BUSY. It has four named transitions:

- **claim** (IDLE to BUSY): a request arrives while `LATENCY` > 0.
- **instant** (IDLE to IDLE): `LATENCY` = 0, so the request completes at once.
- **hold** (BUSY to BUSY): the owner is absent, or the owner presents with wait cycles left, so the countdown steps.
- **finish** (BUSY to IDLE): the owner presents with no wait cycles left.

Internally, owners are coded 0 for the data stage, 1 for fetch and 2 for side.

Top module: `latmem_port`

## Requirements
- R1: On synchronous reset (`rst` = 1 at a clock edge), every stored word becomes zero and any access in progress is dropped. The next request after reset starts a fresh countdown.
- R2: A requester that owns the store and holds its request receives status 0 on `LATENCY` consecutive presented cycles, then status 1 on the next presented cycle.
- R3: With `LATENCY` = 0, a write is given status 1 on the first cycle it is presented.
- R4: A write's data appears on the view port from the cycle after the one that returned status 1. Stored contents do not change on any cycle that returned status 0.
- R5: Word address bits [1:0] select the word within a line, and the upper bits select the line. Word k of a line appears on `view_line` bits [32k+31:32k].
- R6: While one requester owns the store, the other requester receives status 0. Its request neither advances, restarts nor takes over the owner's countdown.
- R7: A request from the non-owner on the cycle the owner completes is not started. That requester's next request needs the full `LATENCY` status-0 cycles before it gets status 1.
- R8: If both requesters present on the same idle cycle, the data stage becomes owner (or completes, when `LATENCY` = 0) and fetch receives status 0.
- R9: A side-port write returns status 1 and is stored at that cycle's edge, even while an access is pending. It never changes the owner or the remaining wait count.
- R10: If a side write and an owner completion hit the same word on the same cycle, the side data is kept.
- R11: The countdown advances only on cycles when the owner presents its request. On cycles when the owner is absent, the remaining count and owner are kept.
- R12: A requester that does not present a request receives status 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dst_valid | input | 1 | Data-stage write request |
| dst_addr | input | ADDR_W | Data-stage word address |
| dst_wdata | input | 32 | Data-stage write data |
| dst_ok | output | 1 | Data-stage status (1 = OK, 0 = WAIT) |
| fet_valid | input | 1 | Fetch-stage write request |
| fet_addr | input | ADDR_W | Fetch-stage word address |
| fet_wdata | input | 32 | Fetch-stage write data |
| fet_ok | output | 1 | Fetch-stage status (1 = OK, 0 = WAIT) |
| side_valid | input | 1 | Side-port write request |
| side_addr | input | ADDR_W | Side-port word address |
| side_wdata | input | 32 | Side-port write data |
| side_ok | output | 1 | Side-port status (1 = OK) |
| view_idx | input | LIDX_W | Line index for the view port |
| view_line | output | 128 | Selected line, word k at bits [32k+31:32k] |

## Verification
The bench builds two copies side by side from the same stimulus: one with `LATENCY` = 3 and `LINES` = 4, and one with `LATENCY` = 0 and `LINES` = 4. The three-cycle copy exposes the count, hold, collision and completion-cycle handover behaviour, as well as a side write that lands during a pending countdown. The zero-latency copy exposes the same-cycle completion path and how the data stage wins on a simultaneous start. Four lines keep the full contents small enough to sweep on every cycle, while still covering both address fields.

// File: rtl/latmem_pkg.sv
`timescale 1ns/1ps
package latmem_pkg;

    // Requester identity
    typedef enum logic [1:0] {
        OWN_DATA  = 2'd0,
        OWN_FETCH = 2'd1,
        OWN_SIDE  = 2'd2
    } own_e;

    // Ownership state machine
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } arb_st_e;

endpackage

// File: rtl/latmem_arbiter.sv
`timescale 1ns/1ps
module latmem_arbiter
    import latmem_pkg::*;
#(
    parameter int LATENCY = 3,
    localparam int CNT_W  = (LATENCY < 3) ? 1 : $clog2(LATENCY)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dst_valid,
    input  logic             fet_valid,
    output logic             dst_ok,
    output logic             fet_ok,
    output logic             commit_en,
    output own_e             commit_src,
    output logic             busy,
    output own_e             owner,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_LOAD = (LATENCY > 0) ? CNT_W'(LATENCY - 1) : '0;
    localparam bit               ZERO_LAT = (LATENCY == 0);

    arb_st_e          st_q, st_d;
    own_e             own_q, own_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             own_present;

    assign own_present = (own_q == OWN_FETCH) ? fet_valid : dst_valid;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            own_q <= OWN_DATA;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            own_q <= own_d;
            cnt_q <= cnt_d;
        end
    end

    // Transitions: claim, instant, hold, finish
    always_comb begin
        st_d  = st_q;
        own_d = own_q;
        cnt_d = cnt_q;
        unique case (st_q)
            ST_IDLE: begin
                if (!ZERO_LAT && (dst_valid || fet_valid)) begin
                    st_d  = ST_BUSY;
                    own_d = dst_valid ? OWN_DATA : OWN_FETCH;
                    cnt_d = CNT_LOAD;
                end
            end
            ST_BUSY: begin
                if (own_present) begin
                    if (cnt_q == '0) st_d = ST_IDLE;
                    else             cnt_d = cnt_q - CNT_W'(1);
                end
            end
        endcase
    end

    // Outputs
    always_comb begin
        dst_ok     = 1'b0;
        fet_ok     = 1'b0;
        commit_en  = 1'b0;
        commit_src = OWN_DATA;
        unique case (st_q)
            ST_IDLE: begin
                if (ZERO_LAT) begin
                    if (dst_valid) begin
                        dst_ok     = 1'b1;
                        commit_en  = 1'b1;
                        commit_src = OWN_DATA;
                    end else if (fet_valid) begin
                        fet_ok     = 1'b1;
                        commit_en  = 1'b1;
                        commit_src = OWN_FETCH;
                    end
                end
            end
            ST_BUSY: begin
                if (own_present && cnt_q == '0) begin
                    commit_en  = 1'b1;
                    commit_src = own_q;
                    if (own_q == OWN_FETCH) fet_ok = 1'b1;
                    else                    dst_ok = 1'b1;
                end
            end
        endcase
    end

    assign busy  = (st_q == ST_BUSY);
    assign owner = own_q;
    assign cnt   = cnt_q;

endmodule

// File: rtl/latmem_wsel.sv
`timescale 1ns/1ps
module latmem_wsel
    import latmem_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int WORD_W = 32
) (
    input  own_e              src,
    input  logic [ADDR_W-1:0] d_addr,
    input  logic [WORD_W-1:0] d_data,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic [WORD_W-1:0] f_data,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] data
);

    always_comb begin
        unique case (src)
            OWN_FETCH: begin
                addr = f_addr;
                data = f_data;
            end
            default: begin
                addr = d_addr;
                data = d_data;
            end
        endcase
    end

endmodule

// File: rtl/latmem_store.sv
`timescale 1ns/1ps
module latmem_store #(
    parameter int LINES  = 16,
    parameter int WORDS  = 4,
    parameter int WORD_W = 32,
    localparam int ADDR_W = $clog2(LINES * WORDS),
    localparam int LIDX_W = $clog2(LINES),
    localparam int LINE_W = WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [WORD_W-1:0] a_data,
    input  logic              b_en,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [WORD_W-1:0] b_data,
    input  logic [LIDX_W-1:0] view_idx,
    output logic [LINE_W-1:0] view_line
);

    logic [LINE_W-1:0] line_arr [LINES];

    for (genvar l = 0; l < LINES; l++) begin : g_line
        logic [LINE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else begin
                for (int w = 0; w < WORDS; w++) begin
                    // side port (b) takes priority over the owner commit (a)
                    if (b_en && b_addr == ADDR_W'(l * WORDS + w))
                        q[w*WORD_W +: WORD_W] <= b_data;
                    else if (a_en && a_addr == ADDR_W'(l * WORDS + w))
                        q[w*WORD_W +: WORD_W] <= a_data;
                end
            end
        end
        assign line_arr[l] = q;
    end

    assign view_line = line_arr[view_idx];

endmodule

// File: rtl/latmem_port.sv
`timescale 1ns/1ps
module latmem_port
    import latmem_pkg::*;
#(
    parameter int LATENCY = 3,
    parameter int LINES   = 16,
    localparam int WORDS  = 4,
    localparam int WORD_W = 32,
    localparam int ADDR_W = $clog2(LINES * WORDS),
    localparam int LIDX_W = $clog2(LINES),
    localparam int LINE_W = WORDS * WORD_W,
    localparam int CNT_W  = (LATENCY < 3) ? 1 : $clog2(LATENCY)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              dst_valid,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [WORD_W-1:0] dst_wdata,
    output logic              dst_ok,
    input  logic              fet_valid,
    input  logic [ADDR_W-1:0] fet_addr,
    input  logic [WORD_W-1:0] fet_wdata,
    output logic              fet_ok,
    input  logic              side_valid,
    input  logic [ADDR_W-1:0] side_addr,
    input  logic [WORD_W-1:0] side_wdata,
    output logic              side_ok,
    input  logic [LIDX_W-1:0] view_idx,
    output logic [LINE_W-1:0] view_line
);

    logic              commit_en;
    own_e              commit_src;
    logic [ADDR_W-1:0] commit_addr;
    logic [WORD_W-1:0] commit_data;
    logic              arb_busy;
    own_e              arb_owner;
    logic [CNT_W-1:0]  arb_cnt;

    latmem_arbiter #(.LATENCY(LATENCY)) u_arb (
        .clk        (clk),
        .rst        (rst),
        .dst_valid  (dst_valid),
        .fet_valid  (fet_valid),
        .dst_ok     (dst_ok),
        .fet_ok     (fet_ok),
        .commit_en  (commit_en),
        .commit_src (commit_src),
        .busy       (arb_busy),
        .owner      (arb_owner),
        .cnt        (arb_cnt)
    );

    latmem_wsel #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_wsel (
        .src    (commit_src),
        .d_addr (dst_addr),
        .d_data (dst_wdata),
        .f_addr (fet_addr),
        .f_data (fet_wdata),
        .addr   (commit_addr),
        .data   (commit_data)
    );

    latmem_store #(.LINES(LINES), .WORDS(WORDS), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .a_en      (commit_en),
        .a_addr    (commit_addr),
        .a_data    (commit_data),
        .b_en      (side_valid),
        .b_addr    (side_addr),
        .b_data    (side_wdata),
        .view_idx  (view_idx),
        .view_line (view_line)
    );

    // side writes complete on the cycle they are presented
    assign side_ok = side_valid;

endmodule

// File: rtl/latmem_port_chk.sv
`timescale 1ns/1ps
module latmem_port_chk
    import latmem_pkg::*;
#(
    parameter int LATENCY = 3,
    localparam int CNT_W  = (LATENCY < 3) ? 1 : $clog2(LATENCY)
) (
    input logic             clk,
    input logic             rst,
    input logic             dst_valid,
    input logic             fet_valid,
    input logic             dst_ok,
    input logic             fet_ok,
    input logic             busy,
    input own_e             owner,
    input logic [CNT_W-1:0] cnt
);

    logic own_pres;
    assign own_pres = (owner == OWN_FETCH) ? fet_valid : dst_valid;

    // R8
    no_dual_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !(dst_ok && fet_ok));

    // R6
    fetch_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && owner == OWN_DATA) |-> !fet_ok);

    // R6
    data_blocked_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && owner == OWN_FETCH) |-> !dst_ok);

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> !busy);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !own_pres) |=> (busy && $stable(cnt) && $stable(owner)));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && own_pres && cnt != '0) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));

    // R2
    finish_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && own_pres && cnt == '0) |=> !busy);

    // R12
    dst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dst_valid |-> !dst_ok);

    // R12
    fet_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !fet_valid |-> !fet_ok);

    if (LATENCY == 0) begin : g_zero
        // R3
        zero_lat_chk: assert property (@(posedge clk) disable iff (rst)
            dst_valid |-> dst_ok);
    end

endmodule

bind latmem_port latmem_port_chk #(.LATENCY(LATENCY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dst_valid (dst_valid),
    .fet_valid (fet_valid),
    .dst_ok    (dst_ok),
    .fet_ok    (fet_ok),
    .busy      (arb_busy),
    .owner     (arb_owner),
    .cnt       (arb_cnt)
);

// File: tb/latmem_port_tb.sv
`timescale 1ns/1ps
module latmem_port_tb;

    localparam int NLINES = 4;
    localparam int NWORDS = NLINES * 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         dv = 1'b0, fv = 1'b0, sv = 1'b0;
    logic [3:0]   da = '0, fa = '0, sa = '0;
    logic [31:0]  dd = '0, fd = '0, sd = '0;
    logic [1:0]   vidx = '0;
    logic         dok [2];
    logic         fok [2];
    logic         sok [2];
    logic [127:0] vline [2];

    int total = 0;
    int bad   = 0;

    // reference model state, one lane per copy
    int          lat    [2] = '{3, 0};
    bit          m_busy [2];
    int          m_own  [2];
    int          m_left [2];
    logic [31:0] m_mem  [2][NWORDS];

    always #2 clk = ~clk;

    latmem_port #(.LATENCY(3), .LINES(NLINES)) u_dut (
        .clk(clk), .rst(rst),
        .dst_valid(dv), .dst_addr(da), .dst_wdata(dd), .dst_ok(dok[0]),
        .fet_valid(fv), .fet_addr(fa), .fet_wdata(fd), .fet_ok(fok[0]),
        .side_valid(sv), .side_addr(sa), .side_wdata(sd), .side_ok(sok[0]),
        .view_idx(vidx), .view_line(vline[0])
    );

    latmem_port #(.LATENCY(0), .LINES(NLINES)) u_dut_z (
        .clk(clk), .rst(rst),
        .dst_valid(dv), .dst_addr(da), .dst_wdata(dd), .dst_ok(dok[1]),
        .fet_valid(fv), .fet_addr(fa), .fet_wdata(fd), .fet_ok(fok[1]),
        .side_valid(sv), .side_addr(sa), .side_wdata(sd), .side_ok(sok[1]),
        .view_idx(vidx), .view_line(vline[1])
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int k, input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s lane%0d %s act=%0h exp=%0h", tag, k, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 2; k++) begin
            m_busy[k] = 1'b0;
            m_own[k]  = 0;
            m_left[k] = 0;
            for (int a = 0; a < NWORDS; a++) m_mem[k][a] = '0;
        end
    endtask

    // one clock cycle: drive, check statuses, step model, sweep contents
    task automatic cyc(input bit i_dv, input logic [3:0] i_da, input logic [31:0] i_dd,
                       input bit i_fv, input logic [3:0] i_fa, input logic [31:0] i_fd,
                       input bit i_sv, input logic [3:0] i_sa, input logic [31:0] i_sd,
                       input string tag);
        bit e_d [2];
        bit e_f [2];
        dv = i_dv; da = i_da; dd = i_dd;
        fv = i_fv; fa = i_fa; fd = i_fd;
        sv = i_sv; sa = i_sa; sd = i_sd;
        #0.5;
        for (int k = 0; k < 2; k++) begin
            bit own_v;
            e_d[k] = 1'b0;
            e_f[k] = 1'b0;
            own_v  = (m_own[k] == 1) ? i_fv : i_dv;
            if (!rst) begin
                if (!m_busy[k]) begin
                    if (lat[k] == 0) begin
                        e_d[k] = i_dv;
                        e_f[k] = i_fv && !i_dv;
                    end
                end else if (own_v && m_left[k] == 0) begin
                    if (m_own[k] == 1) e_f[k] = 1'b1;
                    else               e_d[k] = 1'b1;
                end
            end
            chk(dok[k] === e_d[k], tag, "dst_ok", k, 128'(dok[k]), 128'(e_d[k]));
            chk(fok[k] === e_f[k], tag, "fet_ok", k, 128'(fok[k]), 128'(e_f[k]));
            chk(sok[k] === i_sv,   tag, "side_ok", k, 128'(sok[k]), 128'(i_sv));
        end
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            if (rst) begin
                m_busy[k] = 1'b0;
                m_own[k]  = 0;
                m_left[k] = 0;
                for (int a = 0; a < NWORDS; a++) m_mem[k][a] = '0;
            end else begin
                bit own_v;
                own_v = (m_own[k] == 1) ? i_fv : i_dv;
                if (e_d[k]) m_mem[k][i_da] = i_dd;
                if (e_f[k]) m_mem[k][i_fa] = i_fd;
                if (i_sv)   m_mem[k][i_sa] = i_sd;
                if (!m_busy[k]) begin
                    if (lat[k] > 0 && (i_dv || i_fv)) begin
                        m_busy[k] = 1'b1;
                        m_own[k]  = i_dv ? 0 : 1;
                        m_left[k] = lat[k] - 1;
                    end
                end else if (own_v) begin
                    if (m_left[k] == 0) m_busy[k] = 1'b0;
                    else                m_left[k] = m_left[k] - 1;
                end
            end
        end
        #0.5;
        for (int l = 0; l < NLINES; l++) begin
            vidx = 2'(l);
            #0.1;
            for (int k = 0; k < 2; k++) begin
                logic [127:0] e;
                for (int w = 0; w < 4; w++) e[w*32 +: 32] = m_mem[k][l*4 + w];
                chk(vline[k] === e, tag, $sformatf("line%0d", l), k, vline[k], e);
            end
        end
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic only_d(input logic [3:0] a, input logic [31:0] d, input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, a, d, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic only_f(input logic [3:0] a, input logic [31:0] d, input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 1, a, d, 0, 0, 0, tag);
    endtask

    task automatic both(input logic [3:0] a1, input logic [31:0] d1,
                        input logic [3:0] a2, input logic [31:0] d2, input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(1, a1, d1, 1, a2, d2, 0, 0, 0, tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        idle(tag);
        idle(tag);
        rst = 1'b0;
    endtask

    initial begin
        #800000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        model_clear();
        repeat (2) @(posedge clk);
        #1;
        do_reset("R1");
        idle("R12");
        // latency count and commit visibility
        only_d(4'd0, 32'h1122_3344, 4, "R2");
        only_f(4'd1, 32'h5566_7788, 4, "R5");
        // collision, then handover on the completion cycle
        only_d(4'd2, 32'hA0A0_0002, 2, "R6");
        both(4'd2, 32'hA0A0_0002, 4'd3, 32'hB0B0_0003, 2, "R6");
        only_f(4'd3, 32'hB0B0_0003, 4, "R7");
        // simultaneous start from idle
        idle("R8");
        both(4'd4, 32'hC0C0_0004, 4'd5, 32'hD0D0_0005, 4, "R8");
        only_f(4'd5, 32'hD0D0_0005, 4, "R8");
        // side write during a pending countdown
        only_d(4'd6, 32'hE0E0_0006, 2, "R9");
        cyc(1, 4'd6, 32'hE0E0_0006, 0, 0, 0, 1, 4'd7, 32'hF0F0_0007, "R9");
        only_d(4'd6, 32'hE0E0_0006, 1, "R9");
        // side and owner hit the same word
        only_d(4'd8, 32'h1234_0008, 3, "R10");
        cyc(1, 4'd8, 32'h1234_0008, 0, 0, 0, 1, 4'd8, 32'h9876_0008, "R10");
        // owner pauses while fetch knocks
        only_d(4'd9, 32'h2222_0009, 1, "R11");
        only_f(4'd10, 32'h3333_000A, 2, "R11");
        only_d(4'd9, 32'h2222_0009, 3, "R11");
        // single presentation completes on zero-latency copy
        only_f(4'd10, 32'h4444_000A, 1, "R3");
        only_f(4'd10, 32'h4444_000A, 3, "R3");
        // reset mid-access, then fresh countdown
        only_d(4'd11, 32'h5555_000B, 2, "R1");
        do_reset("R1");
        only_f(4'd12, 32'h6666_000C, 4, "R1");
        // far address fields and wait-cycle stability
        only_d(4'd13, 32'h7777_000D, 4, "R4");
        only_f(4'd15, 32'h8888_000F, 4, "R5");
        idle("R12");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule